// File: doc/BRIEF.md
# Program-Space Window Address Mapper

This block sits in the data-address path of a 16-bit processor. It decides whether a data access falls into the upper half of data space while the program-space window is open. When it does, the access goes to the 24-bit-wide program memory instead of data RAM. The block builds the program-memory address from an 8-bit page register and the low fifteen bits of the effective address. It returns the low sixteen bits of the fetched word as read data.

A redirected access costs extra pipeline cycles, and the block counts them. The number of extra cycles depends on two things: whether the instruction belongs to the light class (multiply-accumulate with a data operand, plain move, double move), and where the access sits within a hardware repeat loop. A loaded down-counter holds the stall request until that number of cycles has elapsed. The processor is expected to present no new access while stall is high.

Top module: `psv_mapper`

## Requirements
- R1: An access is redirected only when acc_req=1, ea[15]=1, win_en=1 and tbl_busy=0. A redirected access drives route_x=1 and pm_en=1 in the same cycle.
- R2: On a redirected access, pm_addr[14:0] equals ea[14:0] and pm_addr[22:15] equals page. pm_addr is zero when the access is not redirected.
- R3: On a redirected access, rd_data equals pm_rdata[15:0], and pm_rdata[23:16] has no effect on it. rd_data is zero otherwise.
- R4: Outside a repeat loop (rpt_act=0), a redirected access with lite_op=1 raises stall for exactly 1 cycle, starting the cycle after the access.
- R5: Outside a repeat loop, a redirected access with lite_op=0 raises stall for exactly 2 cycles.
- R6: Inside a repeat loop (rpt_act=1), stall is raised for exactly 2 cycles if any of rpt_first, rpt_last, irq_exit or irq_back is 1. This holds whatever the value of lite_op.
- R7: Inside a repeat loop with rpt_first, rpt_last, irq_exit and irq_back all 0, a redirected access raises no stall.
- R8: While tbl_busy=1, an access to the upper half has route_x=0, pm_en=0 and raises no stall.
- R9: An access that is not redirected (ea[15]=0 or win_en=0) has route_x=0, meaning data RAM, and raises no stall.
- R10: After reset, stall=0, and it stays 0 until a redirected access arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_req | input | 1 | Data access present this cycle |
| ea | input | 16 | Data effective address |
| win_en | input | 1 | Program-space window enable |
| page | input | 8 | Program page register |
| lite_op | input | 1 | Instruction is in the one-extra-cycle class |
| rpt_act | input | 1 | Repeat loop active |
| rpt_first | input | 1 | First loop iteration |
| rpt_last | input | 1 | Last loop iteration |
| irq_exit | input | 1 | Leaving the loop for an interrupt |
| irq_back | input | 1 | Re-entering the loop after an interrupt |
| tbl_busy | input | 1 | Table read or write in progress |
| pm_rdata | input | 24 | Word returned by program memory |
| pm_addr | output | 23 | Program memory address |
| pm_en | output | 1 | Program memory read enable |
| route_x | output | 1 | 1 = program/X path, 0 = data RAM |
| rd_data | output | 16 | Read data from the window |
| stall | output | 1 | Pipeline hold request |

## Verification
The assertions assume that no access is presented while stall is high. They also assume that the repeat position flags are only meaningful while rpt_act is set. The bench keeps to both: each scenario task raises acc_req for one cycle only, then drops every input to idle and waits for stall to fall before the next access begins. The stall windows asserted after a redirected access are therefore produced by that access alone.

// File: rtl/psv_mapper.sv
module psv_mapper #(
  parameter int DW     = 16,
  parameter int PW     = 24,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_req,
  input  logic [DW-1:0]           ea,
  input  logic                    win_en,
  input  logic [PAGE_W-1:0]       page,
  input  logic                    lite_op,
  input  logic                    rpt_act,
  input  logic                    rpt_first,
  input  logic                    rpt_last,
  input  logic                    irq_exit,
  input  logic                    irq_back,
  input  logic                    tbl_busy,
  input  logic [PW-1:0]           pm_rdata,
  output logic [PAGE_W+DW-2:0]    pm_addr,
  output logic                    pm_en,
  output logic                    route_x,
  output logic [DW-1:0]           rd_data,
  output logic                    stall
);
  localparam int LOW_W = DW - 1;
  localparam logic [CNT_W-1:0] PEN_LITE = CNT_W'(1);
  localparam logic [CNT_W-1:0] PEN_FULL = CNT_W'(2);
  localparam logic [CNT_W-1:0] PEN_NONE = '0;

  logic             hit;
  logic             rpt_edge;
  logic [CNT_W-1:0] pen;
  logic [CNT_W-1:0] cnt;

  assign hit      = acc_req & ea[DW-1] & win_en & ~tbl_busy;
  assign route_x  = hit;
  assign pm_en    = hit;
  assign pm_addr  = hit ? {page, ea[LOW_W-1:0]} : '0;
  assign rd_data  = hit ? pm_rdata[DW-1:0] : '0;
  assign rpt_edge = rpt_first | rpt_last | irq_exit | irq_back;

  always_comb begin
    if (!rpt_act)      pen = lite_op ? PEN_LITE : PEN_FULL;
    else if (rpt_edge) pen = PEN_FULL;
    else               pen = PEN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
    else if (hit)        cnt <= pen;
  end

  assign stall = (cnt != '0);
endmodule

module psv_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic [15:0] ea,
  input logic        win_en,
  input logic        lite_op,
  input logic        rpt_act,
  input logic        rpt_first,
  input logic        rpt_last,
  input logic        irq_exit,
  input logic        irq_back,
  input logic        tbl_busy,
  input logic        route_x,
  input logic        stall
);
  // R1
  route_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_x |-> (acc_req && ea[15] && win_en));
  // R8
  tbl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_busy |-> !route_x);
  // R9
  ram_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_x && !stall) |=> !stall);
  // R4
  lite_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_x && !stall && !rpt_act && lite_op) |=> stall ##1 !stall);
  // R5
  full_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_x && !stall && !rpt_act && !lite_op) |=> stall ##1 stall ##1 !stall);
  // R7
  rpt_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_x && !stall && rpt_act && !rpt_first && !rpt_last && !irq_exit && !irq_back) |=> !stall);
endmodule

bind psv_mapper psv_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .ea(ea), .win_en(win_en),
  .lite_op(lite_op), .rpt_act(rpt_act), .rpt_first(rpt_first), .rpt_last(rpt_last),
  .irq_exit(irq_exit), .irq_back(irq_back), .tbl_busy(tbl_busy),
  .route_x(route_x), .stall(stall)
);

// File: tb/psv_mapper_tb.sv
module psv_mapper_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_req = 0;
  logic [15:0] ea = 0;
  logic        win_en = 0;
  logic [7:0]  page = 0;
  logic        lite_op = 0, rpt_act = 0, rpt_first = 0, rpt_last = 0;
  logic        irq_exit = 0, irq_back = 0, tbl_busy = 0;
  logic [23:0] pm_rdata = 0;
  logic [22:0] pm_addr;
  logic        pm_en, route_x, stall;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psv_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .ea(ea), .win_en(win_en),
    .page(page), .lite_op(lite_op), .rpt_act(rpt_act), .rpt_first(rpt_first),
    .rpt_last(rpt_last), .irq_exit(irq_exit), .irq_back(irq_back),
    .tbl_busy(tbl_busy), .pm_rdata(pm_rdata), .pm_addr(pm_addr), .pm_en(pm_en),
    .route_x(route_x), .rd_data(rd_data), .stall(stall)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    acc_req = 0; ea = 0; win_en = 0; lite_op = 0; rpt_act = 0; rpt_first = 0;
    rpt_last = 0; irq_exit = 0; irq_back = 0; tbl_busy = 0; pm_rdata = 0;
  endtask

  // one access; checks route and returns measured stall length
  task automatic access(input logic [15:0] a, input bit en, input logic [7:0] pg,
                        input logic [23:0] w, input bit lite, input bit ra,
                        input bit rf, input bit rl, input bit ie, input bit ib,
                        input bit tb, output int slen, output bit rx,
                        output logic [22:0] pa, output logic [15:0] rd);
    @(negedge clk);
    acc_req = 1; ea = a; win_en = en; page = pg; pm_rdata = w; lite_op = lite;
    rpt_act = ra; rpt_first = rf; rpt_last = rl; irq_exit = ie; irq_back = ib; tbl_busy = tb;
    #2;
    rx = route_x; pa = pm_addr; rd = rd_data;
    @(negedge clk);
    idle();
    slen = 0;
    for (int i = 0; i < 8 && stall; i++) begin
      slen++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(stall == 0, "R10 stall after reset", stall, 0);
    repeat (3) @(negedge clk);
    chk(stall == 0, "R10 stall idle", stall, 0);
  endtask

  task automatic t_map();
    int s; bit rx; logic [22:0] pa; logic [15:0] rd;
    access(16'hABCD, 1, 8'h5A, 24'hFF1234, 1, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(rx == 1, "R1 route_x on hit", rx, 1);
    chk(pa == {8'h5A, 15'h2BCD}, "R2 pm_addr", pa, {8'h5A, 15'h2BCD});
    chk(rd == 16'h1234, "R3 rd_data low bits", rd, 16'h1234);
    access(16'hFFFE, 1, 8'h01, 24'h00BEEF, 0, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(pa == {8'h01, 15'h7FFE}, "R2 pm_addr top", pa, {8'h01, 15'h7FFE});
    chk(rd == 16'hBEEF, "R3 upper byte ignored", rd, 16'hBEEF);
  endtask

  task automatic t_penalty();
    int s; bit rx; logic [22:0] pa; logic [15:0] rd;
    access(16'h8000, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(s == 1, "R4 lite outside loop", s, 1);
    access(16'h8002, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(s == 2, "R5 other outside loop", s, 2);
    access(16'h8004, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0, s, rx, pa, rd);
    chk(s == 2, "R6 first iteration", s, 2);
    access(16'h8006, 1, 0, 0, 1, 1, 0, 1, 0, 0, 0, s, rx, pa, rd);
    chk(s == 2, "R6 last iteration", s, 2);
    access(16'h8008, 1, 0, 0, 0, 1, 0, 0, 1, 0, 0, s, rx, pa, rd);
    chk(s == 2, "R6 irq exit", s, 2);
    access(16'h800A, 1, 0, 0, 1, 1, 0, 0, 0, 1, 0, s, rx, pa, rd);
    chk(s == 2, "R6 irq re-entry", s, 2);
    access(16'h800C, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(s == 0, "R7 middle iteration lite", s, 0);
    access(16'h800E, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(s == 0, "R7 middle iteration other", s, 0);
  endtask

  task automatic t_table();
    int s; bit rx; logic [22:0] pa; logic [15:0] rd;
    access(16'h9000, 1, 8'h33, 24'h00AAAA, 0, 0, 0, 0, 0, 0, 1, s, rx, pa, rd);
    chk(rx == 0, "R8 route during table op", rx, 0);
    chk(s == 0, "R8 stall during table op", s, 0);
    chk(pa == 0, "R8 pm_addr during table op", pa, 0);
  endtask

  task automatic t_ram();
    int s; bit rx; logic [22:0] pa; logic [15:0] rd;
    access(16'h7FFF, 1, 8'h11, 24'h001111, 0, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(rx == 0, "R9 low half to RAM", rx, 0);
    chk(s == 0, "R9 low half no stall", s, 0);
    chk(rd == 0, "R3 rd_data zero on RAM", rd, 0);
    access(16'hC000, 0, 8'h11, 24'h001111, 0, 0, 0, 0, 0, 0, 0, s, rx, pa, rd);
    chk(rx == 0, "R1 window disabled", rx, 0);
    chk(s == 0, "R9 disabled no stall", s, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_penalty();
    t_table();
    t_ram();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule